// File: doc/BRIEF.md
# Stacked-Carrier Thirteen-Level PWM Gate Generator

This block produces the gate enables for a single-phase inverter made of a chain of full bridges plus one extra half-bridge stage whose source is half the first bridge's source. The extra stage lets the output take a level between each pair of neighbouring bridge levels, so the output has thirteen levels.

A signed, roughly sinusoidal reference is built from a phase accumulator and a computed half-wave shape, then scaled by a modulation-index word. Twelve triangular carriers share one up/down counter. Each carrier sits in its own band: six bands lie below zero and six above. All carriers have the same height and frequency and are in phase. Every carrier is compared with the reference to give one flag. A registered decoder turns the twelve flags into twelve bridge gates and one complementary half-bridge pair. The pair has a programmable dead time.

In use, the reference frequency word, the modulation index and the dead time are set, and the fourteen gate enables drive the power stage's gate drivers.

Top module: `pwm_pd_mc`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears all gates, all flags, the phase accumulator, the carrier prescaler and the triangle counter. The triangle counter restarts at zero, counting up.
- R2: The triangle value t steps once every STEP_DIV clocks. It counts 0,1,...,H-1 and back down to 0, turning at both ends, where H = 2^CAR_W. Carrier k (k = 0..11, flag bit k, named C(k+1)) equals (k-6)*H + t.
- R3: With phase p (PH_W bits) and x = p mod 2^(PH_W-1), shape = (4*x*(2^(PH_W-1)-x)) >> (2*(PH_W-1)-SHAPE_W). Magnitude = (shape*mod_index_i*6*H) >> (SHAPE_W+MI_W). The reference is the negated magnitude when the top phase bit is 1, and the magnitude otherwise. Each clock, p advances by `freq_word_i` modulo 2^PH_W.
- R4: Flag bit k becomes 1 one clock after an edge at which the reference is greater than or equal to carrier k, and 0 otherwise. The reference and t are taken from the current register state. The flag vector is therefore always a run of ones from bit 0 upward.
- R5: One clock after the flags, gate bits 0, 2, 4, 6, 7, 8 and 10 equal flag bits 1, 3, 5, 6, 0, 8 and 10 respectively.
- R6: One clock after the flags: gate bit 1 = (f0^f1)|f6; bit 3 = (f0^f3)|f0; bit 5 = (f0^f5)|f0; bit 9 = (f6^f8)|f6; bit 11 = (f6^f10)|f0.
- R7: The half-bridge requests are taken from the number n of set flags. Request A (gate bit 12) is set when n is 1, 3, 5 or 11. Request B (gate bit 13) is set when n is 2, 4, 8 or 10. These counts are equivalent to the OR of C1^C2, C3^C4, C5^C6 and C11^C12 for A, and of C2^C3, C4^C5, C8^C9 and C10^C11 for B.
- R8: Gate bits 12 and 13 are never high at the same time.
- R9: When gate bit 12 or 13 falls, both stay low for `dead_cycles_i`+1 clocks. After that, each follows its request one clock after the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_index_i | input | MI_W | Modulation index, full scale 2^MI_W |
| freq_word_i | input | PH_W | Phase increment per clock |
| dead_cycles_i | input | DT_W | Half-bridge dead time in clocks, minus one |
| gate_o | output | 14 | Gate enables, bit i drives switch i+1 |
| flag_o | output | 12 | Carrier comparison flags, bit k is C(k+1) |

## Verification
A wrong phase, triangle or prescaler state moves the crossing points. It first shows as a flag vector that differs from the model at a carrier or reference turn, and the gates go wrong one clock later. A stuck dead-time counter shows either as a pair gap that is too short, seen at the next rising half-bridge gate, or as a gate that never returns. Because the bench compares both vectors on every clock against its own model, any divergence is caught within one carrier period of the stimulus that exposes it.

// File: rtl/pwm_pd_pkg.sv
package pwm_pd_pkg;
    localparam int BANDS      = 12;
    localparam int HALF_BANDS = 6;
    localparam int NGATE      = 14;

    typedef enum logic {
        TRI_UP = 1'b0,
        TRI_DN = 1'b1
    } tri_dir_e;
endpackage

// File: rtl/pwm_pd_carrier.sv
module pwm_pd_carrier #(
    parameter int CAR_W    = 8,
    parameter int STEP_DIV = 49
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CAR_W-1:0] tri_o
);
    import pwm_pd_pkg::*;

    localparam int DIVW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

    typedef struct packed {
        logic [DIVW-1:0]  pre;
        logic [CAR_W-1:0] tri_v;
        tri_dir_e         dir;
    } car_st_t;

    car_st_t q, d;

    always_comb begin
        d = q;
        if (q.pre == DIVW'(STEP_DIV - 1)) begin
            d.pre = '0;
            if (q.dir == TRI_UP) begin
                d.tri_v = q.tri_v + 1'b1;
                if (q.tri_v == CAR_W'((2 ** CAR_W) - 2)) d.dir = TRI_DN;
            end else begin
                d.tri_v = q.tri_v - 1'b1;
                if (q.tri_v == CAR_W'(1)) d.dir = TRI_UP;
            end
        end else begin
            d.pre = q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.pre   <= '0;
            q.tri_v <= '0;
            q.dir   <= TRI_UP;
        end else begin
            q <= d;
        end
    end

    assign tri_o = q.tri_v;
endmodule

// File: rtl/pwm_pd_refgen.sv
module pwm_pd_refgen #(
    parameter int PH_W    = 16,
    parameter int MI_W    = 8,
    parameter int CAR_W   = 8,
    parameter int SHAPE_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PH_W-1:0]         freq_word_i,
    input  logic [MI_W-1:0]         mod_index_i,
    output logic signed [CAR_W+4:0] ref_o
);
    import pwm_pd_pkg::*;

    localparam int XW    = PH_W - 1;
    localparam int RW    = CAR_W + 5;
    localparam int PRODW = 2 * PH_W + 2;
    localparam int SHIFT = 2 * XW - SHAPE_W;
    localparam int MAGW  = SHAPE_W + 1 + MI_W + CAR_W + 3;
    localparam int AMP   = HALF_BANDS * (2 ** CAR_W);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } ref_st_t;

    ref_st_t q, d;

    logic [XW-1:0]      x;
    logic [PRODW-1:0]   parab;
    logic [SHAPE_W:0]   shape;
    logic [MAGW-1:0]    scaled;
    logic [CAR_W+2:0]   mag;
    logic signed [RW-1:0] mag_s;

    always_comb begin
        d.phase = q.phase + freq_word_i;
        x       = q.phase[XW-1:0];
        parab   = (PRODW'(x) * (PRODW'(2 ** XW) - PRODW'(x))) << 2;
        shape   = (SHAPE_W + 1)'(parab >> SHIFT);
        scaled  = MAGW'(shape) * MAGW'(mod_index_i) * MAGW'(AMP);
        mag     = (CAR_W + 3)'(scaled >> (SHAPE_W + MI_W));
        mag_s   = $signed({2'b00, mag});
        ref_o   = q.phase[PH_W-1] ? -mag_s : mag_s;
    end

    always_ff @(posedge clk) begin
        if (rst) q.phase <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/pwm_pd_cmpbank.sv
module pwm_pd_cmpbank #(
    parameter int CAR_W = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic signed [CAR_W+4:0]             ref_i,
    input  logic [CAR_W-1:0]                    tri_i,
    output logic [pwm_pd_pkg::BANDS-1:0]        flag_o
);
    import pwm_pd_pkg::*;

    localparam int RW = CAR_W + 5;

    typedef struct packed {
        logic [BANDS-1:0] flags;
    } cmp_st_t;

    cmp_st_t q, d;
    logic [BANDS-1:0] hit;

    for (genvar g = 0; g < BANDS; g++) begin : g_band
        localparam logic signed [RW-1:0] OFS = RW'((g - HALF_BANDS) * (2 ** CAR_W));
        logic signed [RW-1:0] carrier;
        assign carrier = OFS + $signed({5'b00000, tri_i});
        assign hit[g]  = (ref_i >= carrier);
    end

    always_comb begin
        d.flags = hit;
    end

    always_ff @(posedge clk) begin
        if (rst) q.flags <= '0;
        else     q <= d;
    end

    assign flag_o = q.flags;
endmodule

// File: rtl/pwm_pd_gatemap.sv
module pwm_pd_gatemap #(
    parameter int DT_W = 6
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [pwm_pd_pkg::BANDS-1:0]   flag_i,
    input  logic [DT_W-1:0]                dead_cycles_i,
    output logic [pwm_pd_pkg::NGATE-1:0]   gate_o
);
    import pwm_pd_pkg::*;

    typedef struct packed {
        logic [11:0]     hb_gates;
        logic            half_a;
        logic            half_b;
        logic [DT_W-1:0] dead_cnt;
    } map_st_t;

    map_st_t q, d;
    logic    req_a, req_b;

    always_comb begin
        d = q;
        // bridge gates wired straight from single flags
        d.hb_gates[0]  = flag_i[1];
        d.hb_gates[2]  = flag_i[3];
        d.hb_gates[4]  = flag_i[5];
        d.hb_gates[6]  = flag_i[6];
        d.hb_gates[7]  = flag_i[0];
        d.hb_gates[8]  = flag_i[8];
        d.hb_gates[10] = flag_i[10];
        // bridge gates built from a flag pair plus an OR term
        d.hb_gates[1]  = (flag_i[0] ^ flag_i[1]) | flag_i[6];
        d.hb_gates[3]  = (flag_i[0] ^ flag_i[3]) | flag_i[0];
        d.hb_gates[5]  = (flag_i[0] ^ flag_i[5]) | flag_i[0];
        d.hb_gates[9]  = (flag_i[6] ^ flag_i[8]) | flag_i[6];
        d.hb_gates[11] = (flag_i[6] ^ flag_i[10]) | flag_i[0];
        // half-bridge requests: a single band edge inside the flag run
        req_a = (flag_i[0] ^ flag_i[1]) | (flag_i[2] ^ flag_i[3]) |
                (flag_i[4] ^ flag_i[5]) | (flag_i[10] ^ flag_i[11]);
        req_b = (flag_i[1] ^ flag_i[2]) | (flag_i[3] ^ flag_i[4]) |
                (flag_i[7] ^ flag_i[8]) | (flag_i[9] ^ flag_i[10]);
        // dead time on the complementary pair
        if (q.dead_cnt != '0) begin
            d.half_a   = 1'b0;
            d.half_b   = 1'b0;
            d.dead_cnt = q.dead_cnt - 1'b1;
        end else if ((q.half_a && !req_a) || (q.half_b && !req_b)) begin
            d.half_a   = 1'b0;
            d.half_b   = 1'b0;
            d.dead_cnt = dead_cycles_i;
        end else begin
            d.half_a   = req_a;
            d.half_b   = req_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.hb_gates <= '0;
            q.half_a   <= 1'b0;
            q.half_b   <= 1'b0;
            q.dead_cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign gate_o = {q.half_b, q.half_a, q.hb_gates};
endmodule

// File: rtl/pwm_pd_mc.sv
module pwm_pd_mc #(
    parameter int PH_W     = 16,
    parameter int MI_W     = 8,
    parameter int CAR_W    = 8,
    parameter int SHAPE_W  = 12,
    parameter int STEP_DIV = 49,
    parameter int DT_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MI_W-1:0]  mod_index_i,
    input  logic [PH_W-1:0]  freq_word_i,
    input  logic [DT_W-1:0]  dead_cycles_i,
    output logic [13:0]      gate_o,
    output logic [11:0]      flag_o
);
    logic signed [CAR_W+4:0] ref_w;
    logic [CAR_W-1:0]        tri_w;

    pwm_pd_refgen #(
        .PH_W(PH_W), .MI_W(MI_W), .CAR_W(CAR_W), .SHAPE_W(SHAPE_W)
    ) u_ref (
        .clk(clk), .rst(rst), .freq_word_i(freq_word_i),
        .mod_index_i(mod_index_i), .ref_o(ref_w)
    );

    pwm_pd_carrier #(
        .CAR_W(CAR_W), .STEP_DIV(STEP_DIV)
    ) u_car (
        .clk(clk), .rst(rst), .tri_o(tri_w)
    );

    pwm_pd_cmpbank #(
        .CAR_W(CAR_W)
    ) u_cmp (
        .clk(clk), .rst(rst), .ref_i(ref_w), .tri_i(tri_w), .flag_o(flag_o)
    );

    pwm_pd_gatemap #(
        .DT_W(DT_W)
    ) u_map (
        .clk(clk), .rst(rst), .flag_i(flag_o),
        .dead_cycles_i(dead_cycles_i), .gate_o(gate_o)
    );
endmodule

// File: rtl/pwm_pd_mc_chk.sv
module pwm_pd_mc_chk (
    input logic        clk,
    input logic        rst,
    input logic [13:0] gate_o,
    input logic [11:0] flag_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (gate_o == 14'd0 && flag_o == 12'd0));

    a_r4_flag_run: assert property (@(posedge clk) disable iff (rst)
        ((12'(flag_o + 12'd1)) & flag_o) == 12'd0);

    a_r5_s8_tracks_c1: assert property (@(posedge clk) disable iff (rst)
        gate_o[7] == $past(flag_o[0]));

    a_r7_a_needs_request: assert property (@(posedge clk) disable iff (rst)
        gate_o[12] |-> $past((flag_o[0] ^ flag_o[1]) | (flag_o[2] ^ flag_o[3]) |
                             (flag_o[4] ^ flag_o[5]) | (flag_o[10] ^ flag_o[11])));

    a_r8_pair_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(gate_o[12] && gate_o[13]));

    a_r9_gap_after_a: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_o[12]) |-> !gate_o[13]);

    a_r9_gap_after_b: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_o[13]) |-> !gate_o[12]);
endmodule

bind pwm_pd_mc pwm_pd_mc_chk u_chk (
    .clk(clk), .rst(rst), .gate_o(gate_o), .flag_o(flag_o)
);

// File: tb/tb_pwm_pd_mc.sv
module tb_pwm_pd_mc;
    localparam int CW   = 6;
    localparam int DIV  = 2;
    localparam int H    = 1 << CW;
    localparam int AMP  = 6 * H;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mi  = '0;
    logic [15:0] fw  = '0;
    logic [5:0]  dt  = '0;
    wire  [13:0] gate;
    wire  [11:0] flag;

    always #4 clk = ~clk;

    pwm_pd_mc #(.CAR_W(CW), .STEP_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .mod_index_i(mi), .freq_word_i(fw),
        .dead_cycles_i(dt), .gate_o(gate), .flag_o(flag)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural model state
    int          m_phase, m_pre, m_tri, m_up, m_cnt;
    logic [11:0] m_flag;
    logic [13:0] m_gate;

    function automatic int ref_of(input int ph, input int mv);
        longint x, shape, mag;
        x     = ph % 32768;
        shape = (4 * x * (32768 - x)) / 262144;
        mag   = (shape * mv * AMP) / 1048576;
        return (ph >= 32768) ? -int'(mag) : int'(mag);
    endfunction

    always @(posedge clk) begin : model
        int r, n;
        logic [11:0] nf;
        logic [13:0] ng;
        bit ra, rb;
        if (rst) begin
            m_phase = 0; m_pre = 0; m_tri = 0; m_up = 1; m_cnt = 0;
            m_flag = '0; m_gate = '0;
        end else begin
            r = ref_of(m_phase, int'(mi));
            for (int k = 0; k < 12; k++) nf[k] = (r >= (k - 6) * H + m_tri);
            n  = $countones(m_flag);
            ng = '0;
            ng[0]  = m_flag[1];  ng[2] = m_flag[3]; ng[4] = m_flag[5];
            ng[6]  = m_flag[6];  ng[7] = m_flag[0]; ng[8] = m_flag[8];
            ng[10] = m_flag[10];
            ng[1]  = (m_flag[0] != m_flag[1]) || m_flag[6];
            ng[3]  = m_flag[0] || m_flag[3];
            ng[5]  = m_flag[0] || m_flag[5];
            ng[9]  = m_flag[6] || m_flag[8];
            ng[11] = (m_flag[6] != m_flag[10]) || m_flag[0];
            ra = (n == 1) || (n == 3) || (n == 5) || (n == 11);
            rb = (n == 2) || (n == 4) || (n == 8) || (n == 10);
            if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
            end else if ((m_gate[12] && !ra) || (m_gate[13] && !rb)) begin
                m_cnt = int'(dt);
            end else begin
                ng[12] = ra; ng[13] = rb;
            end
            m_phase = (m_phase + int'(fw)) % 65536;
            if (m_pre == DIV - 1) begin
                m_pre = 0;
                if (m_up == 1) begin
                    m_tri = m_tri + 1;
                    if (m_tri == H - 1) m_up = 0;
                end else begin
                    m_tri = m_tri - 1;
                    if (m_tri == 0) m_up = 1;
                end
            end else begin
                m_pre = m_pre + 1;
            end
            m_flag = nf;
            m_gate = ng;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    localparam logic [13:0] DIRECT_M = 14'b00_0101_1101_0101;
    localparam logic [13:0] COMB_M   = 14'b00_1010_0010_1010;

    int low_run  = 0;
    bit fell_any = 0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(flag == m_flag, "R2 R3 R4 flags", int'(flag), int'(m_flag));
            check((gate & DIRECT_M) == (m_gate & DIRECT_M), "R5 direct gates",
                  int'(gate & DIRECT_M), int'(m_gate & DIRECT_M));
            check((gate & COMB_M) == (m_gate & COMB_M), "R6 combined gates",
                  int'(gate & COMB_M), int'(m_gate & COMB_M));
            check(gate[13:12] == m_gate[13:12], "R7 R9 half-bridge pair",
                  int'(gate[13:12]), int'(m_gate[13:12]));
            check(!(gate[12] && gate[13]), "R8 exclusive pair", int'(gate[13:12]), 0);
            // measured gap between a falling and the next rising pair gate
            if (gate[13:12] == 2'b00) begin
                low_run++;
            end else begin
                if (fell_any) begin
                    check(low_run >= int'(dt) + 1, "R9 dead gap", low_run, int'(dt) + 1);
                    fell_any = 0;
                end
                low_run = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (($past(gate[12]) && !gate[12]) || ($past(gate[13]) && !gate[13])) begin
                fell_any = 1;
                low_run  = 1;
            end
        end else begin
            fell_any = 0;
            low_run  = 0;
        end
    end

    task automatic reset_and_check(input logic [7:0] nmi, input logic [15:0] nfw,
                                   input logic [5:0] ndt);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(gate == 14'd0, "R1 gates cleared", int'(gate), 0);
        check(flag == 12'd0, "R1 flags cleared", int'(flag), 0);
        mi = nmi; fw = nfw; dt = ndt;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // phase and triangle at zero: reference 0 meets carriers C1..C7
        check(flag == 12'h07F, "R1 R4 restart flags", int'(flag), 12'h07F);
    endtask

    initial begin
        reset_and_check(8'd255, 16'd600, 6'd3);
        repeat (4000) @(negedge clk);
        mi = 8'd128; fw = 16'd211;
        repeat (3000) @(negedge clk);
        mi = 8'd0;
        repeat (600) @(negedge clk);
        reset_and_check(8'd200, 16'd900, 6'd0);
        repeat (3000) @(negedge clk);
        reset_and_check(8'd255, 16'd37, 6'd20);
        repeat (4000) @(negedge clk);
        reset_and_check(8'd90, 16'd1500, 6'd7);
        repeat (2000) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule